// File: doc/BRIEF.md
# Per-Lane Bitslip Pattern Aligner

This block calibrates the lanes of one parallel bus, any of which may have slipped by one or more bit periods at high data rates. Each lane reaches the block as an already-sampled serial bitstream, one bit per clock. During calibration the source repeats its frame strobe on every lane. That gives each lane a 16-bit frame holding a single one, which opens the frame and is followed by fifteen zeros. A shared frame timer marks a boundary every 16 clocks. At each boundary, every lane reads a 16-bit window out of its own bit history, at an offset set by that lane's slip counter, and compares the window with the one-hot target 0x8000.

Each lane has its own small sequencer with four states:
- **SETTLE**: waits a number of frames.
- **SEARCH**: compares the window at each boundary.
- **LOCKED**: holds the slip that was found.
- **FAILED**: all offsets have been tried without success.

The transitions are:
- **settle-done**: SETTLE to SEARCH, after two frames.
- **step**: SEARCH to SETTLE on a mismatch. The slip counter advances by one.
- **lock**: SEARCH to LOCKED after three consecutive matches.
- **give-up**: SEARCH to FAILED on a mismatch at slip 15.
- **restart**: any state to SETTLE, with all counters cleared.

After reset or restart, every lane begins in SETTLE, so its history is full before the first compare. Calibration is done when every lane is locked. From then on the block delivers one aligned 16-bit word per lane per frame, with the earliest bit in the MSB. The strobe lane is not needed on the data path. Because each lane searches on its own, lanes with aligned timing and lanes with staggered timing are handled in the same way.

Top module: `lane_slip_aligner`

## Requirements
- R1: After reset, every lane_lock and lane_err bit is 0, cal_done is 0 and word_valid is 0.
- R2: A frame boundary occurs every 16 clocks. The boundaries are counted from the clock edge that sampled restart (or from reset). At a boundary, the lane's window is the 16 bits that end slip+1 bits before the boundary, with the earliest bit in the MSB. The window matches when it equals 16'h8000.
- R3: After restart, a lane waits 2 frames and then compares. Each mismatch adds one to the slip and is followed by 2 more settle frames, so slip s is first compared at boundary 3+3s.
- R4: A lane locks after 3 consecutive matching frames. For a stream whose first matching slip is s, lane_lock rises at the edge of boundary 5+3s, 16*(5+3s) clocks after restart. The lock holds until restart.
- R5: cal_done is 1 exactly when every lane_lock bit is 1.
- R6: If slip 15 is compared and fails, lane_err for that lane is set. This happens at boundary 48, 768 clocks after restart. The lane never locks until restart, and cal_done stays 0.
- R7: Lanes calibrate independently. Any mix of per-lane strobe phases from 0 to 15, whether all equal or staggered, locks every lane.
- R8: word_valid pulses for one clock every 16 clocks, and only while cal_done is 1. With the pulse, word_out lane k (bits 16k+15:16k) carries the 16 bits starting at that lane's strobe-one position, with the first bit in the MSB.
- R9: A synchronous restart clears every lock, error and slip on the next edge, and then recalibrates as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one sampled bit per lane per edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Synchronous recalibration request |
| lane_bits | input | LANES | Sampled serial bit of each lane |
| word_out | output | LANES*16 | Aligned frame words, lane k at bits 16k+15:16k |
| word_valid | output | 1 | One-clock pulse when word_out holds a new frame |
| lane_lock | output | LANES | Lane has locked |
| lane_err | output | LANES | Lane tried every slip without a match |
| cal_done | output | 1 | All lanes locked |

## Verification
A slip counter that is wrong, or a sequencer that steps at the wrong moment, changes the edge on which lane_lock rises. The lock edge depends directly on the slip that was found, so one wrong step shifts the rise by three frames (48 clocks). A lock on the wrong offset shows up as a wrong data word at the next word_valid pulse, one frame after lock. A compare limit that is off by one shows at lane_err, either as an error 48 clocks early or late, or as a lane that never reaches the error state. A missed restart clear shows on the edge that sampled restart.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        LN_SETTLE = 2'd0,
        LN_SEARCH = 2'd1,
        LN_LOCKED = 2'd2,
        LN_FAILED = 2'd3
    } lane_state_t;
endpackage

// File: rtl/lsa_frame_timer.sv
module lsa_frame_timer #(
    parameter int FRAME_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(FRAME_W);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == CW'(FRAME_W - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick = (cnt_q == CW'(FRAME_W - 1));
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> !tick); // R2
endmodule

// File: rtl/lsa_deser.sv
module lsa_deser #(
    parameter int FRAME_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_in,
    input  logic [$clog2(FRAME_W)-1:0] slip,
    output logic [FRAME_W-1:0]         window
);
    localparam int HW = 2 * FRAME_W - 1;

    logic [HW-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HW-2:0], bit_in};
        end
    end

    always_comb begin
        window = hist_q[slip +: FRAME_W];
    end
endmodule

// File: rtl/lsa_lane_fsm.sv
module lsa_lane_fsm
    import lsa_pkg::*;
#(
    parameter int FRAME_W    = 16,
    parameter int SETTLE_FRM = 2,
    parameter int LOCK_FRM   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       restart,
    input  logic                       tick,
    input  logic [FRAME_W-1:0]         window,
    output logic [$clog2(FRAME_W)-1:0] slip,
    output logic                       locked,
    output logic                       failed
);
    localparam int SW = $clog2(FRAME_W);
    localparam int TW = $clog2(SETTLE_FRM + 1);
    localparam int MW = $clog2(LOCK_FRM + 1);
    localparam logic [FRAME_W-1:0] TARGET = {1'b1, {(FRAME_W-1){1'b0}}};

    lane_state_t   st_q, st_d;
    logic [SW-1:0] slip_q, slip_d;
    logic [TW-1:0] set_q, set_d;
    logic [MW-1:0] hit_q, hit_d;
    logic          match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LN_SETTLE;
            slip_q <= '0;
            set_q  <= '0;
            hit_q  <= '0;
        end else if (restart) begin
            st_q   <= LN_SETTLE;
            slip_q <= '0;
            set_q  <= '0;
            hit_q  <= '0;
        end else begin
            st_q   <= st_d;
            slip_q <= slip_d;
            set_q  <= set_d;
            hit_q  <= hit_d;
        end
    end

    always_comb begin
        match  = (window == TARGET);
        st_d   = st_q;
        slip_d = slip_q;
        set_d  = set_q;
        hit_d  = hit_q;
        unique case (st_q)
            LN_SETTLE: begin
                if (tick) begin
                    if (set_q == TW'(SETTLE_FRM - 1)) begin
                        st_d  = LN_SEARCH;
                        set_d = '0;
                    end else begin
                        set_d = set_q + 1'b1;
                    end
                end
            end
            LN_SEARCH: begin
                if (tick) begin
                    if (match) begin
                        if (hit_q == MW'(LOCK_FRM - 1)) begin
                            st_d  = LN_LOCKED;
                            hit_d = '0;
                        end else begin
                            hit_d = hit_q + 1'b1;
                        end
                    end else begin
                        hit_d = '0;
                        if (slip_q == SW'(FRAME_W - 1)) begin
                            st_d = LN_FAILED;
                        end else begin
                            slip_d = slip_q + 1'b1;
                            st_d   = LN_SETTLE;
                            set_d  = '0;
                        end
                    end
                end
            end
            LN_LOCKED: st_d = LN_LOCKED;
            LN_FAILED: st_d = LN_FAILED;
            default:   st_d = LN_SETTLE;
        endcase
    end

    always_comb begin
        slip   = slip_q;
        locked = (st_q == LN_LOCKED);
        failed = (st_q == LN_FAILED);
    end

    AST_SLIP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(restart) && slip_q != $past(slip_q)) |-> slip_q == $past(slip_q) + 1'b1); // R3
    AST_STEP_INTO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(restart) && slip_q != $past(slip_q)) |-> st_q == LN_SETTLE); // R3
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> locked); // R4
    AST_FAIL_AT_LAST_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> slip_q == SW'(FRAME_W - 1)); // R6
endmodule

// File: rtl/lane_slip_aligner.sv
module lane_slip_aligner #(
    parameter int LANES      = 4,
    parameter int FRAME_W    = 16,
    parameter int SETTLE_FRM = 2,
    parameter int LOCK_FRM   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic [LANES-1:0]         lane_bits,
    output logic [LANES*FRAME_W-1:0] word_out,
    output logic                     word_valid,
    output logic [LANES-1:0]         lane_lock,
    output logic [LANES-1:0]         lane_err,
    output logic                     cal_done
);
    localparam int SW = $clog2(FRAME_W);

    logic tick;
    logic valid_q;

    lsa_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [FRAME_W-1:0] window;
        logic [SW-1:0]      slip;
        logic [FRAME_W-1:0] word_q;

        lsa_deser #(.FRAME_W(FRAME_W)) u_deser (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_in (lane_bits[k]),
            .slip   (slip),
            .window (window)
        );

        lsa_lane_fsm #(
            .FRAME_W    (FRAME_W),
            .SETTLE_FRM (SETTLE_FRM),
            .LOCK_FRM   (LOCK_FRM)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .tick    (tick),
            .window  (window),
            .slip    (slip),
            .locked  (lane_lock[k]),
            .failed  (lane_err[k])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (tick && lane_lock[k]) begin
                word_q <= window;
            end
        end

        assign word_out[k*FRAME_W +: FRAME_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick && cal_done && !restart;
        end
    end

    always_comb begin
        cal_done   = &lane_lock;
        word_valid = valid_q;
    end

    AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> cal_done); // R8
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (lane_lock == '0 && lane_err == '0 && !word_valid)); // R9
    AST_ERR_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_err) |-> !cal_done); // R6
endmodule

// File: tb/lane_slip_aligner_bench.sv
module lane_slip_aligner_bench;
    localparam int LANES = 4;
    localparam int FW    = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  restart = 1'b0;
    logic [LANES-1:0]      lane_bits = '0;
    logic [LANES*FW-1:0]   word_out;
    logic                  word_valid;
    logic [LANES-1:0]      lane_lock;
    logic [LANES-1:0]      lane_err;
    logic                  cal_done;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          ecount = 0;
    int          rst_edge = 0;
    int          ph [LANES];
    logic [FW-1:0] dw [LANES];
    logic [LANES-1:0] zero_m = '0;
    int          lk_at [LANES];
    int          er_at [LANES];
    int          bad_valid = 0;

    lane_slip_aligner #(.LANES(LANES), .FRAME_W(FW)) u_lane_slip_aligner (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .lane_bits  (lane_bits),
        .word_out   (word_out),
        .word_valid (word_valid),
        .lane_lock  (lane_lock),
        .lane_err   (lane_err),
        .cal_done   (cal_done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    always @(negedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            int pos;
            pos = (((ecount + 1 - ph[k]) % FW) + FW) % FW;
            lane_bits[k] <= zero_m[k] ? 1'b0 : dw[k][FW-1-pos];
        end
        if (word_valid && !cal_done) bad_valid <= bad_valid + 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        rst_edge = ecount + 1;
        @(negedge clk);
        restart = 1'b0;
        check("R9 restart clears lock", lane_lock, 0);
        check("R9 restart clears err", lane_err, 0);
    endtask

    task automatic watch(input int edges);
        for (int k = 0; k < LANES; k++) begin
            lk_at[k] = -1;
            er_at[k] = -1;
        end
        for (int e = 0; e < edges; e++) begin
            @(negedge clk);
            for (int k = 0; k < LANES; k++) begin
                if (lane_lock[k] && lk_at[k] < 0) lk_at[k] = ecount;
                if (lane_err[k] && er_at[k] < 0) er_at[k] = ecount;
            end
        end
    endtask

    function automatic int slip_of(input int p);
        return (((rst_edge - p) % FW) + FW) % FW;
    endfunction

    task automatic check_data(input int trial);
        int last_v;
        int seen;
        for (int k = 0; k < LANES; k++) dw[k] = 16'hA5C3 ^ 16'(trial * 16'h0137) ^ 16'(k * 16'h1111);
        seen = 0;
        last_v = -1;
        while (seen < 7) begin
            @(negedge clk);
            if (word_valid) begin
                seen++;
                if (seen >= 4) begin
                    for (int k = 0; k < LANES; k++)
                        check("R8 aligned data word", word_out[k*FW +: FW], dw[k]);
                    check("R8 valid spacing", ecount - last_v, FW);
                end
                last_v = ecount;
            end
        end
        for (int k = 0; k < LANES; k++) dw[k] = 16'h8000;
    endtask

    task automatic run_trial(input int trial, input bit aligned);
        for (int k = 0; k < LANES; k++) begin
            ph[k] = aligned ? 7 : (trial + 5 * k) % FW;
            dw[k] = 16'h8000;
        end
        repeat (40) @(negedge clk);
        do_restart();
        watch(16 * 52);
        for (int k = 0; k < LANES; k++) begin
            check(aligned ? "R7 aligned lock edge" : "R4 R3 lock edge",
                  lk_at[k] - rst_edge, 16 * (5 + 3 * slip_of(ph[k])));
            check("R6 no error on good lane", lane_err[k], 0);
        end
        check("R5 done with all locks", cal_done, 1);
        check_data(trial);
    endtask

    initial begin
        for (int k = 0; k < LANES; k++) begin
            ph[k] = 0;
            dw[k] = 16'h8000;
        end
        repeat (3) @(negedge clk);
        check("R1 reset lock", lane_lock, 0);
        check("R1 reset err", lane_err, 0);
        check("R1 reset done", cal_done, 0);
        check("R1 reset valid", word_valid, 0);
        rst_n = 1'b1;
        for (int t = 0; t < FW; t++) run_trial(t, 1'b0);
        run_trial(3, 1'b1);
        zero_m = 4'b0100;
        do_restart();
        watch(16 * 52);
        check("R6 error edge", er_at[2] - rst_edge, 16 * 48);
        check("R6 failed lane never locks", lk_at[2], -1);
        check("R5 R6 done held low", cal_done, 0);
        check("R7 other lanes lock", lane_lock & 4'b1011, 4'b1011);
        zero_m = '0;
        do_restart();
        check("R9 error cleared", lane_err, 0);
        watch(16 * 52);
        check("R9 recalibrated", cal_done, 1);
        check("R8 no valid without done", bad_valid, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule